// File: doc/BRIEF.md
# Lock-to-Data Supervisor for a Clock-Recovery Loop

This block supervises a clock and data recovery loop. It chooses whether the loop follows the incoming serial data or falls back to the local reference clock, and it drives an active-low line-fault indicator. The block runs entirely on the reference clock. The reference clock runs at the character rate, which is the serial bit rate divided by 16.

A frequency meter compares recovered character-clock edges with reference cycles. The edges arrive as a free-running, wrapping count that is already synchronous to the reference clock. The meter takes the difference between two snapshots of that count taken one measurement window apart, and checks it against the window length. The default tolerance of ±7 edges over 2^16 reference cycles is roughly ±100 ppm. After a bad window the loop is sent to the reference clock. It returns to the data only after a run of consecutive good windows.

The fault indicator drops at once, with no clock, when either the signal-detect input or the reference-lock input falls. Every other change of the indicator happens on a reference-clock edge. The indicator goes high only when both inputs have been seen high through a synchronizer and the loop is following the data.

Top module: `lock_supervisor`

## Requirements
- R1: While `rstN` is low, `trackData` and `lineFaultN` are both 0. The first measurement window starts at the first clock edge after reset is released.
- R2: A measurement window is exactly 2^WIN_LOG2 reference cycles long. The first window after reset only takes a snapshot of `rcvCount` and yields no verdict.
- R3: A window counts as in range when D lies in [2^WIN_LOG2 − TOL, 2^WIN_LOG2 + TOL], inclusive. D is the later snapshot minus the earlier one, taken modulo 2^CNT_W.
- R4: An out-of-range verdict makes `trackData` 0 (1 = follow data, 0 = follow reference) on the second clock edge after the window's last edge, and resets the run of good windows.
- R5: While following the reference, `trackData` becomes 1 only after GOOD_WINDOWS consecutive in-range windows (default 2). A window is one verdict, that is, one window after it ends.
- R6: While `sigDet` or `refLock` is low, `lineFaultN` is 0. A falling edge on either input drives `lineFaultN` to 0 at once, with no clock edge.
- R7: `lineFaultN` rises only on a clock edge, and only when `trackData` was 1 on the previous cycle and both status inputs have been high. After both inputs are high again it rises on the third clock edge. A pulse between two edges still holds it low until then.
- R8: When `trackData` falls while both status inputs are high, `lineFaultN` falls on the next clock edge.
- R9: `trackData` changes only on the clock edge that follows a window verdict. The status inputs never affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock at the character rate |
| rstN | input | 1 | Asynchronous active-low reset |
| sigDet | input | 1 | Signal-detect status, asynchronous |
| refLock | input | 1 | Reference-lock status, asynchronous |
| rcvCount | input | CNT_W (WIN_LOG2+2) | Free-running count of recovered character-clock edges, synchronous to `clk` |
| trackData | output | 1 | 1: loop follows data; 0: loop follows reference clock |
| lineFaultN | output | 1 | Line-fault indicator, active low |

## Verification
The bench uses a 64-cycle window and sweeps the per-window edge error from −12 to +12, plus gross errors of ±64. It follows each error with two clean windows, so the ±TOL and ±(TOL+1) edges of the range test are checked, and so is the hysteresis. An off-by-one in the comparison would switch on the wrong side of ±7. A one-window hysteresis would return to the data one window early. A design that skipped the priming window would start tracking one window early from the first snapshot.

For the status inputs, the bench checks `lineFaultN` one time unit after a status input falls. It then checks the exact edge on which the indicator recovers, including after a pulse that ends before the next clock edge. A clocked fault path would miss both the instant drop and the short pulse. A missing synchronizer would recover too early.

// File: rtl/lfc_pkg.sv
package lfc_pkg;
  // Verdict strobes from the frequency meter to the tracking control.
  typedef struct packed {
    logic winDone;   // one-cycle strobe: a window verdict is valid
    logic inRange;   // verdict: recovered rate within tolerance
  } meas_t;
endpackage

// File: rtl/lfc_freq_meter.sv
module lfc_freq_meter
  import lfc_pkg::*;
#(
  parameter int WIN_LOG2 = 16,
  parameter int TOL      = 7,
  parameter int CNT_W    = WIN_LOG2 + 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] rcvCount,
  output meas_t            meas
);
  localparam int WIN = 1 << WIN_LOG2;
  localparam logic [CNT_W-1:0] LO_BOUND = CNT_W'(WIN - TOL);
  localparam logic [CNT_W-1:0] HI_BOUND = CNT_W'(WIN + TOL);

  logic [WIN_LOG2-1:0] phase;
  logic                primed;
  logic [CNT_W-1:0]    snap;
  logic [CNT_W-1:0]    delta;
  logic                winEnd;
  logic                inRangeNow;
  meas_t               measQ;

  assign winEnd     = (phase == '1);
  assign delta      = rcvCount - snap;            // modular difference
  assign inRangeNow = (delta >= LO_BOUND) && (delta <= HI_BOUND);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= '0;
      primed <= 1'b0;
      snap   <= '0;
      measQ  <= '0;
    end else begin
      phase         <= phase + 1'b1;
      measQ.winDone <= winEnd && primed;
      measQ.inRange <= winEnd && primed && inRangeNow;
      if (winEnd) begin
        snap   <= rcvCount;
        primed <= 1'b1;
      end
    end
  end

  assign meas = measQ;

  // R2: a verdict strobe lasts exactly one cycle
  p_single_strobe_r2: assert property (@(posedge clk) disable iff (!rstN)
    measQ.winDone |=> !measQ.winDone);
  // R3: an in-range flag only travels with a verdict strobe
  p_range_gated_r3: assert property (@(posedge clk) disable iff (!rstN)
    measQ.inRange |-> measQ.winDone);
endmodule

// File: rtl/lfc_track_ctrl.sv
module lfc_track_ctrl
  import lfc_pkg::*;
#(
  parameter int GOOD_WINDOWS = 2
) (
  input  logic  clk,
  input  logic  rstN,
  input  meas_t meas,
  output logic  trackData
);
  localparam int GW = $clog2(GOOD_WINDOWS + 1);

  logic          trackQ;
  logic [GW-1:0] goodQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trackQ <= 1'b0;
      goodQ  <= '0;
    end else if (meas.winDone) begin
      if (!meas.inRange) begin
        trackQ <= 1'b0;
        goodQ  <= '0;
      end else if (!trackQ) begin
        if (goodQ == GW'(GOOD_WINDOWS - 1)) begin
          trackQ <= 1'b1;
          goodQ  <= '0;
        end else begin
          goodQ <= goodQ + GW'(1);
        end
      end
    end
  end

  assign trackData = trackQ;

  // R4: a bad verdict sends the loop to the reference clock
  p_ref_on_bad_r4: assert property (@(posedge clk) disable iff (!rstN)
    (meas.winDone && !meas.inRange) |=> !trackQ);
  // R5: a return to data only follows a good verdict
  p_rise_needs_good_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(trackQ) |-> ($past(meas.winDone) && $past(meas.inRange)));
  // R9: the select holds between verdicts
  p_hold_between_r9: assert property (@(posedge clk) disable iff (!rstN)
    !meas.winDone |=> $stable(trackQ));
endmodule

// File: rtl/lfc_fault_gen.sv
module lfc_fault_gen #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sigDet,
  input  logic refLock,
  input  logic trackData,
  output logic lineFaultN
);
  logic                   asyncClr;
  logic [SYNC_STAGES-1:0] okPipe;
  logic                   faultQ;

  // Any low status input (or reset) clears the fault path without a clock.
  assign asyncClr = rstN & sigDet & refLock;

  generate
    if (SYNC_STAGES == 1) begin : g_sync_one
      always_ff @(posedge clk or negedge asyncClr) begin
        if (!asyncClr) okPipe <= '0;
        else           okPipe <= 1'b1;
      end
    end else begin : g_sync_chain
      always_ff @(posedge clk or negedge asyncClr) begin
        if (!asyncClr) okPipe <= '0;
        else           okPipe <= {okPipe[SYNC_STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge asyncClr) begin
    if (!asyncClr) faultQ <= 1'b0;
    else           faultQ <= trackData & okPipe[SYNC_STAGES-1];
  end

  assign lineFaultN = faultQ;

  // R6: a low status input always shows as a fault
  p_fault_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!sigDet || !refLock) |-> !lineFaultN);
  // R7: no-fault indication requires data tracking on the previous cycle
  p_fault_follows_track_r7: assert property (@(posedge clk) disable iff (!rstN)
    lineFaultN |-> $past(trackData));
  // R8: losing data tracking raises the fault on the next edge
  p_fault_on_drop_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(trackData) |=> !lineFaultN);
endmodule

// File: rtl/lock_supervisor.sv
module lock_supervisor
  import lfc_pkg::*;
#(
  parameter int WIN_LOG2     = 16,
  parameter int TOL          = 7,
  parameter int GOOD_WINDOWS = 2,
  parameter int SYNC_STAGES  = 2,
  localparam int CNT_W       = WIN_LOG2 + 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sigDet,
  input  logic             refLock,
  input  logic [CNT_W-1:0] rcvCount,
  output logic             trackData,
  output logic             lineFaultN
);
  meas_t meas;

  lfc_freq_meter #(
    .WIN_LOG2 (WIN_LOG2),
    .TOL      (TOL),
    .CNT_W    (CNT_W)
  ) u_meter (
    .clk      (clk),
    .rstN     (rstN),
    .rcvCount (rcvCount),
    .meas     (meas)
  );

  lfc_track_ctrl #(
    .GOOD_WINDOWS (GOOD_WINDOWS)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .meas      (meas),
    .trackData (trackData)
  );

  lfc_fault_gen #(
    .SYNC_STAGES (SYNC_STAGES)
  ) u_fault (
    .clk        (clk),
    .rstN       (rstN),
    .sigDet     (sigDet),
    .refLock    (refLock),
    .trackData  (trackData),
    .lineFaultN (lineFaultN)
  );

  // R1: reset holds both outputs low
  p_reset_outputs_r1: assert property (@(posedge clk)
    !rstN |-> (!trackData && !lineFaultN));
endmodule

// File: tb/lock_supervisor_bench.sv
module lock_supervisor_bench;
  localparam int W     = 6;
  localparam int WIN   = 1 << W;
  localparam int TOL   = 7;
  localparam int GOOD  = 2;
  localparam int CW    = W + 2;

  logic clk = 1'b0;
  logic rstN, sigDet, refLock;
  logic [CW-1:0] rcv;
  logic trackData, lineFaultN;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // Reference model state
  bit expTrack = 1'b0;
  int expGood  = 0;
  bit pend     = 1'b0;
  int lastErr  = 0;

  always #2.5 clk = ~clk;   // 200 MHz

  lock_supervisor #(
    .WIN_LOG2(W), .TOL(TOL), .GOOD_WINDOWS(GOOD), .SYNC_STAGES(2)
  ) u_lock_supervisor (
    .clk(clk), .rstN(rstN), .sigDet(sigDet), .refLock(refLock),
    .rcvCount(rcv), .trackData(trackData), .lineFaultN(lineFaultN)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b (last window error %0d)", req, act, exp, lastErr);
    end
  endtask

  // mode 0: plain; 1: sigDet pulse; 2: refLock pulse; 3: sub-cycle sigDet glitch
  task automatic runWin(input int e, input int mode);
    for (int c = 0; c < WIN; c++) begin
      @(negedge clk);
      if (c == 2 && pend) begin
        check("R3 R4 R5 trackData", trackData, expTrack);
        check("R7 R8 lineFaultN", lineFaultN, expTrack);
      end
      if ((mode == 1 || mode == 2) && c == 10) begin
        if (mode == 1) sigDet = 1'b0; else refLock = 1'b0;
        #1;
        check("R6 immediate drop", lineFaultN, 1'b0);
      end
      if ((mode == 1 || mode == 2) && c == 15) begin
        check("R9 select ignores status", trackData, expTrack);
        check("R6 held low", lineFaultN, 1'b0);
      end
      if ((mode == 1 || mode == 2) && c == 20) begin
        sigDet = 1'b1; refLock = 1'b1;
      end
      if ((mode == 1 || mode == 2) && c == 22) check("R7 low two edges after", lineFaultN, 1'b0);
      if ((mode == 1 || mode == 2) && c == 23) check("R7 high third edge", lineFaultN, expTrack);
      if (mode == 3 && c == 30) begin
        sigDet = 1'b0;
        #1;
        check("R6 glitch drop", lineFaultN, 1'b0);
        #1;
        sigDet = 1'b1;
      end
      if (mode == 3 && c == 32) check("R7 glitch low two edges after", lineFaultN, 1'b0);
      if (mode == 3 && c == 33) check("R7 glitch high third edge", lineFaultN, expTrack);
      rcv = rcv + ((c == 0) ? CW'(1 + e) : CW'(1));
    end
    // model update for the window just finished
    lastErr = e;
    if (e < -TOL || e > TOL) begin
      expTrack = 1'b0;
      expGood  = 0;
    end else if (!expTrack) begin
      expGood++;
      if (expGood == GOOD) begin
        expTrack = 1'b1;
        expGood  = 0;
      end
    end
    pend = 1'b1;
  endtask

  initial begin
    rstN = 1'b0; sigDet = 1'b1; refLock = 1'b1; rcv = '0;
    repeat (4) @(negedge clk);
    check("R1 reset trackData", trackData, 1'b0);
    check("R1 reset lineFaultN", lineFaultN, 1'b0);
    // Priming window: release at a negedge; exactly WIN edges by its end,
    // which a design without priming would wrongly accept as a good window.
    @(negedge clk);
    rstN = 1'b1;
    rcv  = rcv + 1'b1;
    for (int c = 1; c < WIN; c++) begin
      @(negedge clk);
      rcv = rcv + 1'b1;
    end
    runWin(0, 0);              // first verdict: one good window (R2 checks no tracking yet)
    runWin(0, 0);              // second good window: tracking starts
    for (int e = -12; e <= 12; e++) begin
      runWin(e, 0);
      runWin(0, 0);
      runWin(0, 0);
    end
    runWin(WIN, 0);            // double rate
    runWin(0, 0);
    runWin(-WIN, 0);           // no edges at all
    runWin(0, 0);
    runWin(0, 0);
    runWin(0, 1);              // signal-detect pulse while tracking
    runWin(0, 2);              // reference-lock pulse while tracking
    runWin(0, 3);              // sub-cycle glitch
    runWin(9, 0);              // drop to reference
    runWin(0, 1);              // status pulse while on reference
    runWin(0, 0);
    runWin(0, 0);              // flush last expectation
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule